// File: doc/BRIEF.md
# Shared-Chroma Pixel Codec

This block converts between two pixel stream formats. The compact format is a 24-bit word with a 10-bit luma sample on every pixel and a single 10-bit chroma field that carries blue-difference (Cb) and red-difference (Cr) samples on alternate pixels. The full format carries luma, Cb and Cr on every pixel. The block has two independent paths that share one clock and reset. The expand path turns compact words into full pixels. The compact path turns full pixels back into compact words.

Each side of each path is a pixel stream. It has a valid strobe and a 4-bit marker vector. Marker bit 0 flags the first pixel of a line, bit 1 the last pixel of a line, bit 2 the first pixel of a frame and bit 3 the last pixel of a frame. The chroma phase is counted only on valid pixels and restarts at every line-start pixel. That pixel is always position 0 and carries Cb.

The expand path pairs each Cb with the Cr that follows it, so it holds one pixel back. The markers travel with their pixel through that delay. The compact path needs no pairing and answers one cycle after its input.

Top module: `chroma444_codec`

## Requirements
- R1: After reset is released, `fx_valid` and `pw_valid` stay low until input pixels arrive.
- R2: Compact word layout: luma in bits 9:0, chroma in bits 19:10, padding in bits 23:20. The padding of an input word is ignored. The padding of an output word is always zero.
- R3: The chroma phase restarts on a valid pixel with marker bit 0 set. That pixel is position 0 (even, Cb). Positions then alternate odd (Cr) and even (Cb).
- R4: Expand path, normal pairing. An even pixel is output with its own chroma as Cb and the next pixel's chroma as Cr. An odd pixel is output with the preceding pixel's chroma as Cb and its own chroma as Cr. Luma passes through unchanged.
- R5: Expand path, unpaired pixel. An even pixel that ends its line, or that is followed by another even pixel, is output with its own chroma as both Cb and Cr.
- R6: Expand path timing. A pixel appears on the output the cycle after the next valid input pixel is accepted. A pixel with marker bit 1 set appears two clock edges after it is accepted, even if no further input arrives.
- R7: On both paths, the markers leave the block together with the pixel they arrived with, unchanged.
- R8: Compact path. Each valid input appears one cycle later with luma copied, Cb selected on even positions and Cr selected on odd positions.
- R9: Cycles with valid low do not advance the chroma phase. Their data and markers have no effect on either path's output stream. On the compact path they produce no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pk_valid | input | 1 | Compact input pixel valid |
| pk_data | input | 24 | Compact input word |
| pk_mark | input | 4 | Compact input markers (0 line start, 1 line end, 2 frame start, 3 frame end) |
| fx_valid | output | 1 | Full output pixel valid |
| fx_y | output | 10 | Full output luma |
| fx_cb | output | 10 | Full output Cb |
| fx_cr | output | 10 | Full output Cr |
| fx_mark | output | 4 | Full output markers |
| ix_valid | input | 1 | Full input pixel valid |
| ix_y | input | 10 | Full input luma |
| ix_cb | input | 10 | Full input Cb |
| ix_cr | input | 10 | Full input Cr |
| ix_mark | input | 4 | Full input markers |
| pw_valid | output | 1 | Compact output word valid |
| pw_data | output | 24 | Compact output word |
| pw_mark | output | 4 | Compact output markers |

## Verification
On the expand path, two events can fall in the same cycle. One is the flush of a held line-end pixel. The other is the loading of the next line's first pixel into the same holding stage. The bench provokes this collision by sending lines of every length from one to eight back to back, with no idle cycles between them. Single-pixel lines are included, so a flush can also be immediately followed by another flush. The bench judges the result by checking the full ordered output stream against pixels it derives from the pairing rules. Any lost, doubled or reordered pixel, and any chroma taken from the wrong neighbour, shows up as a mismatch.

// File: rtl/chroma_pkg.sv
package chroma_pkg;

  // Marker bits that travel alongside every pixel.
  typedef struct packed {
    logic frame_end;
    logic frame_start;
    logic line_end;
    logic line_start;
  } mark_t;

endpackage

// File: rtl/phase_tracker.sv
// Tracks the even/odd position of valid pixels within a line.
module phase_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  input  logic restart_i,
  output logic par_o
);

  logic odd_q;
  logic odd_d;

  always_comb begin
    par_o = restart_i ? 1'b0 : odd_q;
    odd_d = step_i ? ~par_o : odd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odd_q <= 1'b0;
    end else begin
      odd_q <= odd_d;
    end
  end

endmodule

// File: rtl/chroma_unpack.sv
// Expands shared-chroma words into full pixels using a one-pixel holding stage.
module chroma_unpack
  import chroma_pkg::*;
#(
  parameter int COMP_W = 10,
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  mark_t             in_mark,
  output logic              out_valid,
  output logic [COMP_W-1:0] out_y,
  output logic [COMP_W-1:0] out_cb,
  output logic [COMP_W-1:0] out_cr,
  output mark_t             out_mark
);

  logic              in_par;
  logic [COMP_W-1:0] in_y;
  logic [COMP_W-1:0] in_c;

  // holding stage
  logic              st_full_q, st_full_d;
  logic              st_odd_q,  st_odd_d;
  logic [COMP_W-1:0] st_y_q,    st_y_d;
  logic [COMP_W-1:0] st_c_q,    st_c_d;
  mark_t             st_mark_q, st_mark_d;
  logic [COMP_W-1:0] last_cb_q, last_cb_d;

  // output register
  logic              emit;
  logic [COMP_W-1:0] e_cb, e_cr;
  logic              ov_q, ov_d;
  logic [COMP_W-1:0] oy_q, oy_d;
  logic [COMP_W-1:0] ocb_q, ocb_d;
  logic [COMP_W-1:0] ocr_q, ocr_d;
  mark_t             om_q, om_d;

  phase_tracker u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (in_valid),
    .restart_i (in_mark.line_start),
    .par_o     (in_par)
  );

  always_comb begin
    in_y = in_word[COMP_W-1:0];
    in_c = in_word[2*COMP_W-1:COMP_W];

    // The held pixel leaves when a successor arrives or when it ends a line.
    emit = st_full_q & (in_valid | st_mark_q.line_end);

    if (st_odd_q) begin
      e_cb = last_cb_q;
      e_cr = st_c_q;
    end else begin
      e_cb = st_c_q;
      e_cr = (in_valid & in_par) ? in_c : st_c_q;
    end

    st_full_d = in_valid | (st_full_q & ~emit);
    st_odd_d  = in_valid ? in_par  : st_odd_q;
    st_y_d    = in_valid ? in_y    : st_y_q;
    st_c_d    = in_valid ? in_c    : st_c_q;
    st_mark_d = in_valid ? in_mark : st_mark_q;
    last_cb_d = (in_valid & ~in_par) ? in_c : last_cb_q;

    ov_d  = emit;
    oy_d  = emit ? st_y_q    : oy_q;
    ocb_d = emit ? e_cb      : ocb_q;
    ocr_d = emit ? e_cr      : ocr_q;
    om_d  = emit ? st_mark_q : om_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_full_q <= 1'b0;
      st_odd_q  <= 1'b0;
      st_y_q    <= '0;
      st_c_q    <= '0;
      st_mark_q <= '0;
      last_cb_q <= '0;
      ov_q      <= 1'b0;
      oy_q      <= '0;
      ocb_q     <= '0;
      ocr_q     <= '0;
      om_q      <= '0;
    end else begin
      st_full_q <= st_full_d;
      st_odd_q  <= st_odd_d;
      st_y_q    <= st_y_d;
      st_c_q    <= st_c_d;
      st_mark_q <= st_mark_d;
      last_cb_q <= last_cb_d;
      ov_q      <= ov_d;
      oy_q      <= oy_d;
      ocb_q     <= ocb_d;
      ocr_q     <= ocr_d;
      om_q      <= om_d;
    end
  end

  assign out_valid = ov_q;
  assign out_y     = oy_q;
  assign out_cb    = ocb_q;
  assign out_cr    = ocr_q;
  assign out_mark  = om_q;

endmodule

// File: rtl/chroma_pack.sv
// Packs full pixels into shared-chroma words, picking chroma by position.
module chroma_pack
  import chroma_pkg::*;
#(
  parameter int COMP_W = 10,
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [COMP_W-1:0] in_y,
  input  logic [COMP_W-1:0] in_cb,
  input  logic [COMP_W-1:0] in_cr,
  input  mark_t             in_mark,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output mark_t             out_mark
);

  localparam int PAD_W = WORD_W - 2 * COMP_W;

  logic              in_par;
  logic [COMP_W-1:0] sel_c;
  logic [WORD_W-1:0] packed_w;

  logic              ov_q, ov_d;
  logic [WORD_W-1:0] ow_q, ow_d;
  mark_t             om_q, om_d;

  phase_tracker u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (in_valid),
    .restart_i (in_mark.line_start),
    .par_o     (in_par)
  );

  assign sel_c = in_par ? in_cr : in_cb;

  generate
    if (PAD_W > 0) begin : g_pad
      assign packed_w = {{PAD_W{1'b0}}, sel_c, in_y};
    end else begin : g_nopad
      assign packed_w = {sel_c, in_y};
    end
  endgenerate

  always_comb begin
    ov_d = in_valid;
    ow_d = in_valid ? packed_w : ow_q;
    om_d = in_valid ? in_mark  : om_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      ow_q <= '0;
      om_q <= '0;
    end else begin
      ov_q <= ov_d;
      ow_q <= ow_d;
      om_q <= om_d;
    end
  end

  assign out_valid = ov_q;
  assign out_word  = ow_q;
  assign out_mark  = om_q;

endmodule

// File: rtl/chroma444_codec.sv
// Top: shared-chroma to full-pixel expand path and full-pixel to shared-chroma compact path.
module chroma444_codec
  import chroma_pkg::*;
#(
  parameter int COMP_W = 10,
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pk_valid,
  input  logic [WORD_W-1:0] pk_data,
  input  logic [3:0]        pk_mark,
  output logic              fx_valid,
  output logic [COMP_W-1:0] fx_y,
  output logic [COMP_W-1:0] fx_cb,
  output logic [COMP_W-1:0] fx_cr,
  output logic [3:0]        fx_mark,
  input  logic              ix_valid,
  input  logic [COMP_W-1:0] ix_y,
  input  logic [COMP_W-1:0] ix_cb,
  input  logic [COMP_W-1:0] ix_cr,
  input  logic [3:0]        ix_mark,
  output logic              pw_valid,
  output logic [WORD_W-1:0] pw_data,
  output logic [3:0]        pw_mark
);

  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_n_s;
  mark_t             fx_mark_s;
  mark_t             pw_mark_s;

  // Reset asserts at once and is released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
    end
  end

  assign rst_n_s = rst_sync_q[SYNC_N-1];

  chroma_unpack #(
    .COMP_W (COMP_W),
    .WORD_W (WORD_W)
  ) u_unpack (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .in_valid  (pk_valid),
    .in_word   (pk_data),
    .in_mark   (mark_t'(pk_mark)),
    .out_valid (fx_valid),
    .out_y     (fx_y),
    .out_cb    (fx_cb),
    .out_cr    (fx_cr),
    .out_mark  (fx_mark_s)
  );

  chroma_pack #(
    .COMP_W (COMP_W),
    .WORD_W (WORD_W)
  ) u_pack (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .in_valid  (ix_valid),
    .in_y      (ix_y),
    .in_cb     (ix_cb),
    .in_cr     (ix_cr),
    .in_mark   (mark_t'(ix_mark)),
    .out_valid (pw_valid),
    .out_word  (pw_data),
    .out_mark  (pw_mark_s)
  );

  assign fx_mark = fx_mark_s;
  assign pw_mark = pw_mark_s;

endmodule

// File: rtl/chroma444_codec_chk.sv
// Protocol checker attached to the codec top.
module chroma444_codec_chk #(
  parameter int COMP_W = 10,
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              pk_valid,
  input logic [3:0]        pk_mark,
  input logic              fx_valid,
  input logic [3:0]        fx_mark,
  input logic              ix_valid,
  input logic [COMP_W-1:0] ix_y,
  input logic [COMP_W-1:0] ix_cb,
  input logic [3:0]        ix_mark,
  input logic              pw_valid,
  input logic [WORD_W-1:0] pw_data,
  input logic [3:0]        pw_mark
);

  p_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    pw_valid |-> (pw_data[WORD_W-1:2*COMP_W] == '0));

  p_line_start_cb_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (ix_valid && ix_mark[0]) |=> (pw_data[2*COMP_W-1:COMP_W] == $past(ix_cb)));

  p_eol_flush_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (pk_valid && pk_mark[1]) |=> ##1 (fx_valid && fx_mark[1]));

  p_mark_follow_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    ix_valid |=> (pw_mark == $past(ix_mark)));

  p_down_follow_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    ix_valid |=> pw_valid);

  p_down_luma_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    ix_valid |=> (pw_data[COMP_W-1:0] == $past(ix_y)));

  p_down_idle_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    !ix_valid |=> !pw_valid);

endmodule

bind chroma444_codec chroma444_codec_chk #(
  .COMP_W (COMP_W),
  .WORD_W (WORD_W)
) u_chk (
  .clk      (clk),
  .rst_ni   (rst_n_s),
  .pk_valid (pk_valid),
  .pk_mark  (pk_mark),
  .fx_valid (fx_valid),
  .fx_mark  (fx_mark),
  .ix_valid (ix_valid),
  .ix_y     (ix_y),
  .ix_cb    (ix_cb),
  .ix_mark  (ix_mark),
  .pw_valid (pw_valid),
  .pw_data  (pw_data),
  .pw_mark  (pw_mark)
);

// File: tb/tb_chroma444_codec.sv
module tb_chroma444_codec;

  logic        clk;
  logic        rst_n;
  logic        pk_valid;
  logic [23:0] pk_data;
  logic [3:0]  pk_mark;
  logic        fx_valid;
  logic [9:0]  fx_y, fx_cb, fx_cr;
  logic [3:0]  fx_mark;
  logic        ix_valid;
  logic [9:0]  ix_y, ix_cb, ix_cr;
  logic [3:0]  ix_mark;
  logic        pw_valid;
  logic [23:0] pw_data;
  logic [3:0]  pw_mark;

  int n_chk = 0;
  int n_bad = 0;
  bit mon_on = 0;
  bit done = 0;

  logic [43:0] up_q[$];  // {mark, y, cb, cr}
  logic [27:0] dn_q[$];  // {mark, word}

  chroma444_codec dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .pk_valid (pk_valid),
    .pk_data  (pk_data),
    .pk_mark  (pk_mark),
    .fx_valid (fx_valid),
    .fx_y     (fx_y),
    .fx_cb    (fx_cb),
    .fx_cr    (fx_cr),
    .fx_mark  (fx_mark),
    .ix_valid (ix_valid),
    .ix_y     (ix_y),
    .ix_cb    (ix_cb),
    .ix_cr    (ix_cr),
    .ix_mark  (ix_mark),
    .pw_valid (pw_valid),
    .pw_data  (pw_data),
    .pw_mark  (pw_mark)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Idle cycle: junk data and markers with valid low (R9, R2 padding ignored).
  task automatic idle_cycle();
    @(negedge clk);
    pk_valid = 1'b0; pk_data = 24'hFFFFFF; pk_mark = 4'hF;
    ix_valid = 1'b0; ix_y = 10'h3FF; ix_cb = 10'h3FF; ix_cr = 10'h3FF; ix_mark = 4'hF;
  endtask

  // Sends one line on both paths and queues the expected outputs.
  task automatic send_line(input int len, input int ln, input bit fs, input bit fe, input int gm);
    logic [9:0] ya[8];
    logic [9:0] cba[8];
    logic [9:0] cra[8];
    logic [9:0] pca[8];
    logic [3:0] mk;
    logic [9:0] ecb, ecr;
    for (int k = 0; k < len; k++) begin
      ya[k]  = 10'((ln * 97 + k * 13 + 5) % 1024);
      cba[k] = 10'((ln * 41 + k * 29 + 300) % 1024);
      cra[k] = 10'((ln * 71 + k * 17 + 600) % 1024);
      pca[k] = (k % 2 == 1) ? cra[k] : cba[k];
    end
    for (int k = 0; k < len; k++) begin
      int g;
      g = (gm == 0) ? 0 : ((k * gm + ln) % 3);
      repeat (g) idle_cycle();
      mk = {fe && (k == len - 1), fs && (k == 0), k == len - 1, k == 0};
      if (k % 2 == 1) begin
        ecb = pca[k-1];
        ecr = pca[k];
      end else begin
        ecb = pca[k];
        ecr = (k + 1 < len) ? pca[k+1] : pca[k];
      end
      @(negedge clk);
      pk_valid = 1'b1; pk_data = {4'hA, pca[k], ya[k]}; pk_mark = mk;
      ix_valid = 1'b1; ix_y = ya[k]; ix_cb = cba[k]; ix_cr = cra[k]; ix_mark = mk;
      up_q.push_back({mk, ya[k], ecb, ecr});
      dn_q.push_back({mk, 4'h0, (k % 2 == 1) ? cra[k] : cba[k], ya[k]});
    end
  endtask

  // Output monitor: ordered stream comparison on both paths.
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (fx_valid) begin
          if (up_q.size() == 0) begin
            check(1'b0, "R6 expand path emitted an unexpected pixel", 64'({fx_mark, fx_y, fx_cb, fx_cr}), 64'(0));
          end else begin
            logic [43:0] e;
            e = up_q.pop_front();
            check({fx_mark, fx_y, fx_cb, fx_cr} == e,
                  "R3/R4/R5/R7/R9 expand path pixel {mark,y,cb,cr}",
                  64'({fx_mark, fx_y, fx_cb, fx_cr}), 64'(e));
          end
        end
        if (pw_valid) begin
          if (dn_q.size() == 0) begin
            check(1'b0, "R9 compact path emitted an unexpected word", 64'({pw_mark, pw_data}), 64'(0));
          end else begin
            logic [27:0] e;
            e = dn_q.pop_front();
            check({pw_mark, pw_data} == e,
                  "R2/R3/R7/R8/R9 compact path word {mark,word}",
                  64'({pw_mark, pw_data}), 64'(e));
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int ln;
    rst_n = 1'b0;
    pk_valid = 1'b0; pk_data = '0; pk_mark = '0;
    ix_valid = 1'b0; ix_y = '0; ix_cb = '0; ix_cr = '0; ix_mark = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(fx_valid == 1'b0, "R1 fx_valid after reset", 64'(fx_valid), 64'(0));
    check(pw_valid == 1'b0, "R1 pw_valid after reset", 64'(pw_valid), 64'(0));

    mon_on = 1'b1;

    // R6: a lone line-end pixel flushes two edges after acceptance.
    send_line(1, 0, 1'b1, 1'b1, 0);
    idle_cycle();
    check(fx_valid == 1'b0, "R6 expand output one edge after line-end pixel", 64'(fx_valid), 64'(0));
    check(pw_valid == 1'b1, "R8 compact output one edge after input", 64'(pw_valid), 64'(1));
    idle_cycle();
    check(fx_valid == 1'b1, "R6 expand output two edges after line-end pixel", 64'(fx_valid), 64'(1));
    check(pw_valid == 1'b0, "R9 compact output idle after idle input", 64'(pw_valid), 64'(0));
    repeat (3) idle_cycle();

    // Sweep: every line length 1..8 under three idle-gap patterns.
    ln = 1;
    for (int gm = 0; gm < 3; gm++) begin
      for (int len = 1; len <= 8; len++) begin
        send_line(len, ln, len == 1, len == 8, gm);
        ln++;
      end
      // second pass with a repeated short/long mix, back to back
      for (int len = 8; len >= 1; len--) begin
        send_line(len, ln, len == 8, len == 1, gm);
        ln++;
      end
    end
    repeat (10) idle_cycle();

    // R6/R8: nothing left pending after the stream drains.
    check(up_q.size() == 0, "R6 expand path pixels still pending", 64'(up_q.size()), 64'(0));
    check(dn_q.size() == 0, "R8 compact path words still pending", 64'(dn_q.size()), 64'(0));

    done = 1'b1;
    finish_run();
  end

endmodule